// File: doc/BRIEF.md
# Table-Driven Square-Wave Melody Player

This block plays short tunes on a one-bit speaker output. A tune lives in an external table as a run of two-word entries: a pitch word, which sets how many clock cycles each half of the square wave lasts, and a length word, which says how many complete waves the note lasts. The player reads the table through a synchronous read port, plays each note in turn and stops when it reads an end code. Two pitch values are reserved. A pitch whose low bits match the pause pattern keeps the divider running but holds the speaker low. A pitch matching the end pattern stops playback.

A one-cycle start strobe, typically from a minute sequencer, starts playback. The read pointer is not reset between tunes. It stays on the word after the last end code, so each new strobe plays the next tune in the table. While a note sounds, the player already fetches the following entry. This lets consecutive notes join without a gap.

Top module: `melody_player`

## Requirements
- R1: After reset `spk_o` and `busy_o` are low and `rd_addr_o` is 0.
- R2: A note with pitch word D drives `spk_o` high for D cycles and then low for D cycles, repeating. Each note starts with its high half, so the tone frequency is the clock divided by 2·D. Ordinary pitch values are at least 4.
- R3: An entry is the pitch word at the pointer followed by the length word at pointer+1. The note lasts N complete waves, where N is the low DUR_W bits of the length word.
- R4: A length field of 0 plays 2^DUR_W complete waves, not a short note.
- R5: A pitch word w with (w & CODE_MASK) == PAUSE_PAT is a pause (defaults: mask 16'h0003, pattern 16'h0001). The divider runs with w as half period for the programmed number of waves, and `spk_o` stays low throughout.
- R6: A pitch word with (w & CODE_MASK) == END_PAT (default 16'h0003) ends the tune. `busy_o` falls on the clock edge that ends the last note, and the pointer then addresses the word after the end code.
- R7: Consecutive note entries play back to back. The first high half of a note follows the last low half of the previous note in the very next cycle.
- R8: A start strobe seen while idle resumes reading at the saved pointer, so successive strobes play successive tunes.
- R9: A start strobe while `busy_o` is high is ignored and does not disturb the waveform or the pointer.
- R10: `busy_o` goes high in the cycle after an accepted start strobe and stays high until the end code is consumed. `spk_o` is low whenever `busy_o` is low. An end code at the pointer gives a few busy cycles with no sound.
- R11: The table port is synchronous. `rd_data_i` holds the word at the address that `rd_addr_o` showed in the previous cycle. The address only ever advances by one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle start strobe |
| rd_addr_o | output | ADDR_W | Table word address |
| rd_data_i | input | 16 | Table word, one cycle after its address |
| spk_o | output | 1 | Square-wave speaker output |
| busy_o | output | 1 | High while a tune is being fetched or played |

## Verification
On every cycle, the assertions check the following: the speaker stays silent whenever the player is idle; the divider count stays below the active half period; the saved pointer holds still while idle; a fetched entry is held until it is consumed; and the table address only steps by one. Only the bench scenarios can show the waveform itself. These scenarios compare the exact high and low run lengths, the seamless joins between notes, silence for a pause, the very long note a zero length gives, a strobe ignored in mid-tune, and the pointer carrying over from one tune to the next.

// File: rtl/melody_pkg.sv
package melody_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [2:0] {
        F_IDLE,
        F_WAIT_P,
        F_PITCH,
        F_WAIT_L,
        F_LEN,
        F_FULL
    } fetch_st_e;

    typedef enum logic [1:0] {
        P_IDLE,
        P_WAIT,
        P_PLAY
    } play_st_e;

endpackage

// File: rtl/mp_fetch.sv
module mp_fetch
    import melody_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DUR_W = 16,
    parameter logic [WORD_W-1:0] CODE_MASK = 16'h0003,
    parameter logic [WORD_W-1:0] PAUSE_PAT = 16'h0001,
    parameter logic [WORD_W-1:0] END_PAT = 16'h0003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick_i,
    input  logic              take_i,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              full_o,
    output logic [WORD_W-1:0] div_o,
    output logic [DUR_W-1:0]  len_o,
    output logic              pause_o,
    output logic              fin_o
);

    typedef struct packed {
        fetch_st_e          st;
        logic [ADDR_W-1:0]  ptr;
        logic [WORD_W-1:0]  div;
        logic [DUR_W-1:0]   len;
        logic               pause;
        logic               fin;
    } fetch_t;

    fetch_t fetch_d, fetch_q;
    logic   code_pause, code_fin;

    assign code_pause = (rd_data_i & CODE_MASK) == PAUSE_PAT;
    assign code_fin   = (rd_data_i & CODE_MASK) == END_PAT;

    always_comb begin
        fetch_d = fetch_q;
        case (fetch_q.st)
            F_IDLE: begin
                if (kick_i) fetch_d.st = F_WAIT_P;
            end
            F_WAIT_P: fetch_d.st = F_PITCH;
            F_PITCH: begin
                fetch_d.ptr   = fetch_q.ptr + 1'b1;
                fetch_d.div   = rd_data_i;
                fetch_d.pause = code_pause;
                fetch_d.fin   = code_fin;
                fetch_d.len   = '0;
                fetch_d.st    = code_fin ? F_FULL : F_WAIT_L;
            end
            F_WAIT_L: fetch_d.st = F_LEN;
            F_LEN: begin
                fetch_d.ptr = fetch_q.ptr + 1'b1;
                fetch_d.len = rd_data_i[DUR_W-1:0];
                fetch_d.st  = F_FULL;
            end
            F_FULL: begin
                if (take_i) fetch_d.st = fetch_q.fin ? F_IDLE : F_WAIT_P;
            end
            default: fetch_d.st = F_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_q       <= '0;
            fetch_q.st    <= F_IDLE;
        end else begin
            fetch_q <= fetch_d;
        end
    end

    assign rd_addr_o = fetch_q.ptr;
    assign full_o    = fetch_q.st == F_FULL;
    assign div_o     = fetch_q.div;
    assign len_o     = fetch_q.len;
    assign pause_o   = fetch_q.pause;
    assign fin_o     = fetch_q.fin;

    // R8: the pointer survives idle periods untouched
    assert_ptr_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_q.st == F_IDLE && !kick_i) |=> $stable(fetch_q.ptr));

    // R7: a prefetched entry waits unchanged until it is consumed
    assert_entry_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !take_i) |=> (full_o && $stable(div_o) && $stable(len_o)));

endmodule

// File: rtl/mp_voice.sv
module mp_voice
    import melody_pkg::*;
#(
    parameter int DUR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              stop_i,
    input  logic [WORD_W-1:0] div_i,
    input  logic [DUR_W-1:0]  len_i,
    input  logic              pause_i,
    output logic              spk_o,
    output logic              done_o
);

    typedef struct packed {
        logic               active;
        logic               pause;
        logic               phase;
        logic [WORD_W-1:0]  div;
        logic [WORD_W-1:0]  cnt;
        logic [DUR_W-1:0]   left;
    } voice_t;

    voice_t voice_d, voice_q;
    logic   half_end;

    assign half_end = voice_q.cnt == (voice_q.div - 1'b1);
    assign done_o   = voice_q.active && half_end && voice_q.phase
                      && (voice_q.left == {{(DUR_W-1){1'b0}}, 1'b1});

    always_comb begin
        voice_d = voice_q;
        if (voice_q.active) begin
            if (half_end) begin
                voice_d.cnt   = '0;
                voice_d.phase = ~voice_q.phase;
                if (voice_q.phase) voice_d.left = voice_q.left - 1'b1;
            end else begin
                voice_d.cnt = voice_q.cnt + 1'b1;
            end
        end
        if (stop_i) begin
            voice_d.active = 1'b0;
            voice_d.phase  = 1'b0;
            voice_d.cnt    = '0;
        end
        if (load_i) begin
            voice_d.active = 1'b1;
            voice_d.pause  = pause_i;
            voice_d.phase  = 1'b0;
            voice_d.div    = div_i;
            voice_d.cnt    = '0;
            voice_d.left   = len_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) voice_q <= '0;
        else        voice_q <= voice_d;
    end

    assign spk_o = voice_q.active && !voice_q.pause && !voice_q.phase;

    // R2: the half-period counter never passes the divider
    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        voice_q.active |-> (voice_q.cnt < voice_q.div));

endmodule

// File: rtl/melody_player.sv
module melody_player
    import melody_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DUR_W = 16,
    parameter logic [WORD_W-1:0] CODE_MASK = 16'h0003,
    parameter logic [WORD_W-1:0] PAUSE_PAT = 16'h0001,
    parameter logic [WORD_W-1:0] END_PAT = 16'h0003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic              spk_o,
    output logic              busy_o
);

    typedef struct packed {
        play_st_e st;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              kick, take, load, stop;
    logic              full, fin, pause, done;
    logic [WORD_W-1:0] div;
    logic [DUR_W-1:0]  len;

    mp_fetch #(
        .ADDR_W    (ADDR_W),
        .DUR_W     (DUR_W),
        .CODE_MASK (CODE_MASK),
        .PAUSE_PAT (PAUSE_PAT),
        .END_PAT   (END_PAT)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .kick_i    (kick),
        .take_i    (take),
        .rd_data_i (rd_data_i),
        .rd_addr_o (rd_addr_o),
        .full_o    (full),
        .div_o     (div),
        .len_o     (len),
        .pause_o   (pause),
        .fin_o     (fin)
    );

    mp_voice #(
        .DUR_W (DUR_W)
    ) u_voice (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .stop_i  (stop),
        .div_i   (div),
        .len_i   (len),
        .pause_i (pause),
        .spk_o   (spk_o),
        .done_o  (done)
    );

    always_comb begin
        ctl_d = ctl_q;
        kick  = 1'b0;
        take  = 1'b0;
        load  = 1'b0;
        stop  = 1'b0;
        case (ctl_q.st)
            P_IDLE: begin
                if (start_i) begin
                    kick     = 1'b1;
                    ctl_d.st = P_WAIT;
                end
            end
            P_WAIT: begin
                if (full) begin
                    take = 1'b1;
                    if (fin) begin
                        ctl_d.st = P_IDLE;
                    end else begin
                        load     = 1'b1;
                        ctl_d.st = P_PLAY;
                    end
                end
            end
            P_PLAY: begin
                if (done) begin
                    if (full) begin
                        take = 1'b1;
                        if (fin) begin
                            stop     = 1'b1;
                            ctl_d.st = P_IDLE;
                        end else begin
                            load = 1'b1;
                        end
                    end else begin
                        stop     = 1'b1;
                        ctl_d.st = P_WAIT;
                    end
                end
            end
            default: ctl_d.st = P_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q.st <= P_IDLE;
        else        ctl_q    <= ctl_d;
    end

    assign busy_o = ctl_q.st != P_IDLE;

    // R10: no sound unless a tune is in progress
    assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !spk_o);

    // R11: the table address only ever steps forward by one word
    assert_addr_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_o != $past(rd_addr_o)) |-> (rd_addr_o == ADDR_W'($past(rd_addr_o) + 1'b1)));

endmodule

// File: tb/tb_melody_player.sv
module tb_melody_player;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 6;
    localparam int DUR_W = 8;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [15:0] ENDW = 16'h0003;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] rd_addr_o;
    logic [15:0]       rd_data_i;
    logic              spk_o;
    logic              busy_o;
    logic [15:0]       mem [DEPTH];

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_ff @(posedge clk) rd_data_i <= mem[rd_addr_o];

    melody_player #(
        .ADDR_W (ADDR_W),
        .DUR_W  (DUR_W)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .rd_addr_o (rd_addr_o),
        .rd_data_i (rd_data_i),
        .spk_o     (spk_o),
        .busy_o    (busy_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_sound(input string req);
        int k;
        k = 0;
        while (!spk_o && k < 20) begin
            @(negedge clk);
            k++;
        end
        chk(spk_o == 1'b1, req, int'(spk_o), 1);
    endtask

    // Walk the table from base, comparing spk_o each cycle.
    // ign_at >= 0 pulses start at that cycle index (R9).
    task automatic play_check(input int base, input int ign_at, input string req);
        int p, k;
        p = base;
        k = 0;
        forever begin
            logic [15:0] w;
            int n, bad;
            bit quiet;
            w = mem[p];
            if ((w & 16'h0003) == 16'h0003) begin
                p++;
                break;
            end
            quiet = (w & 16'h0003) == 16'h0001;
            n = (mem[p+1][DUR_W-1:0] == 0) ? (1 << DUR_W) : int'(mem[p+1][DUR_W-1:0]);
            bad = 0;
            for (int wv = 0; wv < n; wv++) begin
                for (int h = 0; h < 2; h++) begin
                    for (int c = 0; c < int'(w); c++) begin
                        bit e;
                        e = !quiet && (h == 0);
                        if (spk_o !== e) bad++;
                        start_i = (k == ign_at);
                        @(negedge clk);
                        k++;
                    end
                end
            end
            start_i = 1'b0;
            chk(bad == 0, $sformatf("%s entry@%0d mismatched cycles", req, p), bad, 0);
            p += 2;
        end
        chk(busy_o == 1'b0, "R6 busy falls after end code", int'(busy_o), 0);
        chk(spk_o == 1'b0, "R10 silent after tune", int'(spk_o), 0);
        chk(int'(rd_addr_o) == p, "R6 pointer past end code", int'(rd_addr_o), p);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = ENDW;
        // tune at 0: plain notes (R2, R3, R7)
        mem[0] = 16'd4;  mem[1] = 16'd2;
        mem[2] = 16'd6;  mem[3] = 16'd1;
        mem[4] = 16'd8;  mem[5] = 16'd3;
        mem[6] = ENDW;
        // tune at 7: pause between notes (R5)
        mem[7]  = 16'd6; mem[8]  = 16'd2;
        mem[9]  = 16'd5; mem[10] = 16'd1;
        mem[11] = 16'd4; mem[12] = 16'd1;
        mem[13] = ENDW;
        // tune at 14: empty
        mem[14] = ENDW;
        // tune at 15: zero length (R4)
        mem[15] = 16'd4;  mem[16] = 16'h0100;
        mem[17] = 16'd10; mem[18] = 16'd1;
        mem[19] = ENDW;
        // tune at 20: sweep of pitches and lengths
        for (int i = 0; i < 6; i++) begin
            mem[20 + 2*i] = 16'(4 + 2*i);
            mem[21 + 2*i] = 16'(1 + (i % 3));
        end
        mem[32] = ENDW;

        repeat (3) @(negedge clk);
        chk(spk_o == 1'b0, "R1 spk after reset", int'(spk_o), 0);
        chk(busy_o == 1'b0, "R1 busy after reset", int'(busy_o), 0);
        chk(rd_addr_o == '0, "R1 address after reset", int'(rd_addr_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(rd_addr_o == '0, "R8 pointer idle without strobe", int'(rd_addr_o), 0);

        // R2 R3 R7 R9 R11
        pulse_start();
        chk(busy_o == 1'b1, "R10 busy after start", int'(busy_o), 1);
        wait_sound("R2 first note sounds");
        play_check(0, 10, "R2/R3/R7/R9 notes");

        repeat (5) @(negedge clk);
        // R8 next tune, R5 pause
        pulse_start();
        wait_sound("R8 second tune sounds");
        play_check(7, -1, "R5/R8 pause tune");

        // R6 R10 empty tune
        repeat (4) @(negedge clk);
        begin
            int hi;
            hi = 0;
            pulse_start();
            chk(busy_o == 1'b1, "R10 busy on empty tune", int'(busy_o), 1);
            for (int i = 0; i < 8; i++) begin
                if (spk_o) hi++;
                @(negedge clk);
            end
            chk(hi == 0, "R10 empty tune silent", hi, 0);
            chk(busy_o == 1'b0, "R6 empty tune ends", int'(busy_o), 0);
            chk(int'(rd_addr_o) == 15, "R6 pointer after empty tune", int'(rd_addr_o), 15);
        end

        // R4 zero length
        pulse_start();
        wait_sound("R4 long note sounds");
        play_check(15, -1, "R4 zero length note");

        // sweep
        repeat (2) @(negedge clk);
        pulse_start();
        wait_sound("R2 sweep sounds");
        play_check(20, -1, "R2/R3/R7/R11 sweep");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule